// File: doc/BRIEF.md
# Performance Event Counter Unit

This block sits beside a processor core and counts two kinds of event in six counters: completed instructions and clock cycles. Counters 1 to 4 each pick their event through an 8-bit selector code. Counter 5 always counts completed instructions, and counter 6 always counts cycle ticks. Each clock the core reports how many instructions completed, which may be more than one, along with a cycle tick and a run-latch status bit.

Software reaches the counters and two control words through one register port. A write is applied at the clock edge. A read returns the addressed register combinationally.

- **Control word A** holds three freeze bits, two overflow enables and an exception enable.
- **Control word B** holds the four selector fields.

A counter's value reaching the sign bit (0x80000000) is an overflow. If that counter's overflow enable is set, the counter is pinned at exactly 0x80000000. When the exception enable is also set, a one-cycle pulse appears on the overflow output.

Top module: `perf_counter_unit`

## Requirements
- R1: Counter 5 (address 4) adds the instruction count every cycle it is not frozen. Counter 6 (address 5) adds one on every cycle in which the cycle tick is high. Neither depends on the selector fields.
- R2: On counters 1 to 4, selector 0x02 counts instructions and selector 0x1E counts cycle ticks. Control word B (address 7) places the selector for counter k in bits [8k-1:8k-8].
- R3: Selectors 0xF0 (cycles) and 0xFE (instructions) are honoured only on counter 1. On counters 2 to 4 they select nothing.
- R4: Selector 0xFA is honoured only on counter 4. It adds the instruction count only in cycles when the run-latch input is high.
- R5: Control word A (address 6) has three freeze bits:
  - bit 0 holds all six counters;
  - bit 1 holds counters 1 to 4;
  - bit 2 holds counters 5 and 6.
- R6: A counter whose selector code is not recognised for that counter keeps its value.
- R7: Overflow enables sit in control word A: bit 3 covers counter 1, and bit 4 covers counters 2 to 6.
  - With its enable set, a counting counter whose sum reaches or passes 0x80000000 (a carry out of bit 31 included) is set to exactly 0x80000000.
  - With its enable clear, the counter passes the threshold and wraps modulo 2^32.
- R8: The overflow output is high for one cycle, the cycle in which an enabled counter is first set to 0x80000000 by counting. It is raised only if control word A bit 5 was set in the cycle before.
- R9: A register write to a counter (addresses 0 to 5 hold counters 1 to 6) replaces that cycle's increment and raises no overflow.
- R10: A write to a control word changes counting from the following cycle only.
- R11: Synchronous active-low reset clears every counter and both control words, and drives the overflow output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_cnt | input | IW | Instructions completed this cycle |
| cyc_tick | input | 1 | Cycle tick |
| run_latch | input | 1 | Run-latch status |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address: 0-5 counters, 6 control A, 7 control B |
| wdata | input | CW | Write data |
| rd_data | output | CW | Read data for `addr` |
| ovf_irq | output | 1 | Overflow exception pulse |

## Verification
The bench builds the unit with its defaults: a 32-bit counter width and a 4-bit instruction count. Counters can be preloaded through the write port. A preload just under 0x80000000, followed by a burst of three instructions, carries a counter past the threshold in one step. This reaches the clamp, the shared and private overflow enables, and the wrap with the enable clear, within a few cycles. A three-instruction burst also separates instruction counting from cycle counting in every selector case.

// File: rtl/perf_counter_unit.sv
module perf_counter_unit #(
  parameter int CW = 32,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] insn_cnt,
  input  logic          cyc_tick,
  input  logic          run_latch,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rd_data,
  output logic          ovf_irq
);
  localparam int NC = 6;
  localparam int SW = 8;
  localparam logic [CW-1:0] TH = {1'b1, {(CW-1){1'b0}}};

  logic [5:0]           ctl_a;
  logic [4*SW-1:0]      ctl_b;
  logic [NC-1:0][CW-1:0] cnt_q;
  logic [NC-1:0]        hit;

  wire frz_all = ctl_a[0];
  wire frz_lo  = ctl_a[1];
  wire frz_hi  = ctl_a[2];
  wire ove_one = ctl_a[3];
  wire ove_rst = ctl_a[4];
  wire exc_en  = ctl_a[5];

  for (genvar j = 0; j < NC; j++) begin : g_cnt
    logic          is_ins, is_cyc, is_rl;
    logic [CW-1:0] inc;
    logic [CW:0]   sum;
    logic          frz, active, oven, wsel, clamp;

    if (j < 4) begin : g_sel
      logic [SW-1:0] sel;
      assign sel    = ctl_b[SW*j +: SW];
      assign is_ins = (sel == 8'h02) || (j == 0 && sel == 8'hFE);
      assign is_cyc = (sel == 8'h1E) || (j == 0 && sel == 8'hF0);
      assign is_rl  = (j == 3 && sel == 8'hFA);
    end else begin : g_fix
      assign is_ins = (j == 4);
      assign is_cyc = (j == 5);
      assign is_rl  = 1'b0;
    end

    assign frz    = frz_all | ((j < 4) ? frz_lo : frz_hi);
    assign active = !frz && (is_ins || is_cyc || is_rl);
    assign inc    = is_cyc ? CW'(cyc_tick) :
                    (is_ins || (is_rl && run_latch)) ? CW'(insn_cnt) : '0;
    assign sum    = {1'b0, cnt_q[j]} + {1'b0, inc};
    assign oven   = (j == 0) ? ove_one : ove_rst;
    assign wsel   = wr_en && (addr == 3'(j));
    assign clamp  = active && oven && (sum >= {1'b0, TH});
    assign hit[j] = clamp && !wsel && (cnt_q[j] != TH);

    always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q[j] <= '0;
      else if (wsel)   cnt_q[j] <= wdata;
      else if (clamp)  cnt_q[j] <= TH;
      else if (active) cnt_q[j] <= sum[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_a   <= '0;
      ctl_b   <= '0;
      ovf_irq <= 1'b0;
    end else begin
      if (wr_en && addr == 3'd6) ctl_a <= wdata[5:0];
      if (wr_en && addr == 3'd7) ctl_b <= wdata[4*SW-1:0];
      ovf_irq <= exc_en && (|hit);
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NC; k++)
      if (addr == 3'(k)) rd_data = cnt_q[k];
    if (addr == 3'd6) rd_data = CW'(ctl_a);
    if (addr == 3'd7) rd_data = CW'(ctl_b);
  end
endmodule

module perf_counter_unit_chk #(
  parameter int CW = 32,
  parameter int IW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [2:0]           addr,
  input logic [CW-1:0]        wdata,
  input logic [IW-1:0]        insn_cnt,
  input logic                 ovf_irq,
  input logic [5:0]           ctl_a,
  input logic [5:0][CW-1:0]   cnt_q
);
  localparam logic [CW-1:0] TH = {1'b1, {(CW-1){1'b0}}};

  logic any_th;
  always_comb begin
    any_th = 1'b0;
    for (int k = 0; k < 6; k++) if (cnt_q[k] == TH) any_th = 1'b1;
  end

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> $past(ctl_a[5]));

  assert_irq_at_th_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> any_th);

  assert_ctl_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd6) |=> (ctl_a == $past(wdata[5:0])));

  assert_fixed_ins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_a[0] && !ctl_a[2] && !ctl_a[4] && !(wr_en && addr == 3'd4))
      |=> (cnt_q[4] == $past(cnt_q[4] + CW'(insn_cnt))));

  for (genvar j = 0; j < 6; j++) begin : g_chk
    assert_wr_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 3'(j)) |=> (cnt_q[j] == $past(wdata)));
    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_a[0] && !(wr_en && addr == 3'(j))) |=> $stable(cnt_q[j]));
  end
endmodule

bind perf_counter_unit perf_counter_unit_chk #(.CW(CW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .insn_cnt(insn_cnt), .ovf_irq(ovf_irq), .ctl_a(ctl_a), .cnt_q(cnt_q)
);

// File: tb/sim_perf_counter_unit.sv
module sim_perf_counter_unit;
  localparam int CW = 32;
  localparam int IW = 4;
  localparam int NV = 18;
  localparam int RUNLEN = 5;

  logic clk = 0, rst_n = 0, cyc_tick = 0, run_latch = 0, wr_en = 0;
  logic [IW-1:0] insn_cnt = '0;
  logic [2:0]    addr = '0;
  logic [CW-1:0] wdata = '0, rd_data;
  logic          ovf_irq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  perf_counter_unit #(.CW(CW), .IW(IW)) u0 (.*);

  typedef struct packed {
    logic [7:0]  ca;
    logic [31:0] cb;
    logic [3:0]  ins;
    logic        cyc;
    logic        run;
    logic [2:0]  idx;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    {8'h0, 32'h00000002, 4'd3, 1'b1, 1'b1, 3'd0, 32'd15, 4'd2},  // R2
    {8'h0, 32'h00001E00, 4'd3, 1'b1, 1'b1, 3'd1, 32'd5,  4'd2},  // R2
    {8'h0, 32'h000000F0, 4'd3, 1'b1, 1'b1, 3'd0, 32'd5,  4'd3},  // R3
    {8'h0, 32'h0000F000, 4'd3, 1'b1, 1'b1, 3'd1, 32'd0,  4'd3},  // R3
    {8'h0, 32'h000000FE, 4'd3, 1'b1, 1'b1, 3'd0, 32'd15, 4'd3},  // R3
    {8'h0, 32'h00FE0000, 4'd3, 1'b1, 1'b1, 3'd2, 32'd0,  4'd3},  // R3
    {8'h0, 32'hFA000000, 4'd3, 1'b1, 1'b1, 3'd3, 32'd15, 4'd4},  // R4
    {8'h0, 32'hFA000000, 4'd3, 1'b1, 1'b0, 3'd3, 32'd0,  4'd4},  // R4
    {8'h0, 32'h00FA0000, 4'd3, 1'b1, 1'b1, 3'd2, 32'd0,  4'd4},  // R4
    {8'h0, 32'h00000000, 4'd3, 1'b1, 1'b1, 3'd4, 32'd15, 4'd1},  // R1
    {8'h0, 32'h00000000, 4'd3, 1'b1, 1'b1, 3'd5, 32'd5,  4'd1},  // R1
    {8'h1, 32'h00000002, 4'd3, 1'b1, 1'b1, 3'd0, 32'd0,  4'd5},  // R5
    {8'h2, 32'h00000000, 4'd3, 1'b1, 1'b1, 3'd4, 32'd15, 4'd5},  // R5
    {8'h2, 32'h00000002, 4'd3, 1'b1, 1'b1, 3'd0, 32'd0,  4'd5},  // R5
    {8'h4, 32'h00000000, 4'd3, 1'b1, 1'b1, 3'd5, 32'd0,  4'd5},  // R5
    {8'h4, 32'h00001E00, 4'd3, 1'b1, 1'b1, 3'd1, 32'd5,  4'd5},  // R5
    {8'h0, 32'h00005500, 4'd3, 1'b1, 1'b1, 3'd1, 32'd0,  4'd6},  // R6
    {8'h0, 32'h00000000, 4'd3, 1'b0, 1'b1, 3'd5, 32'd0,  4'd1}   // R1
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    wr_en = 1; addr = a; wdata = d;
    step();
    wr_en = 0;
  endtask

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [CW-1:0] exp);
    addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    // R11: reset state
    for (int a = 0; a < 8; a++) rd(3'(a), "R11", '0);
    chk("R11", {31'd0, ovf_irq}, 0);

    foreach (VEC[v]) begin
      wr(3'd6, 1);
      for (int a = 0; a < 6; a++) wr(3'(a), 0);
      wr(3'd7, VEC[v].cb);
      insn_cnt = VEC[v].ins; cyc_tick = VEC[v].cyc; run_latch = VEC[v].run;
      wr(3'd6, CW'(VEC[v].ca));
      repeat (RUNLEN - 1) step();
      wr(3'd6, 1);
      rd(VEC[v].idx, $sformatf("R%0d vec%0d", VEC[v].req, v), VEC[v].exp);
    end
    cyc_tick = 0; run_latch = 0; insn_cnt = 3;

    // R7 R8: private enable clamps counter 1 and pulses once
    wr(3'd0, 32'h7FFFFFFE);
    wr(3'd7, 32'h02);
    wr(3'd6, 32'h28);
    step();
    rd(3'd0, "R7 clamp", 32'h80000000);
    chk("R8 pulse", {31'd0, ovf_irq}, 1);
    step();
    rd(3'd0, "R7 hold", 32'h80000000);
    chk("R8 one cycle", {31'd0, ovf_irq}, 0);
    wr(3'd6, 1);

    // R8: exception enable clear, no pulse
    wr(3'd0, 32'h7FFFFFFE);
    wr(3'd6, 32'h08);
    step();
    rd(3'd0, "R7 clamp noexc", 32'h80000000);
    chk("R8 gated", {31'd0, ovf_irq}, 0);
    wr(3'd6, 1);

    // R7: counter 2 ignores the counter-1 enable and passes the threshold
    wr(3'd0, 0);
    wr(3'd1, 32'h7FFFFFFE);
    wr(3'd7, 32'h0200);
    wr(3'd6, 32'h28);
    step();
    rd(3'd1, "R7 wrap", 32'h80000001);
    chk("R8 none", {31'd0, ovf_irq}, 0);
    wr(3'd6, 1);

    // R7 R8: shared enable on counter 6
    wr(3'd1, 0);
    wr(3'd4, 0);
    wr(3'd5, 32'h7FFFFFFF);
    cyc_tick = 1;
    wr(3'd6, 32'h30);
    step();
    rd(3'd5, "R7 cnt6 clamp", 32'h80000000);
    chk("R8 cnt6 pulse", {31'd0, ovf_irq}, 1);
    wr(3'd6, 1);
    cyc_tick = 0;

    // R9: write beats increment
    wr(3'd4, 0);
    wr(3'd6, 0);
    wr(3'd4, 100);
    rd(3'd4, "R9 write wins", 100);
    step();
    rd(3'd4, "R9 resume", 103);
    wr(3'd6, 1);

    // R10: control write effective next cycle
    wr(3'd7, 32'h02);
    wr(3'd0, 0);
    wr(3'd6, 0);
    rd(3'd0, "R10 same edge", 0);
    step();
    rd(3'd0, "R10 next", 3);
    rd(3'd7, "R10 readback", 32'h02);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule